// File: doc/BRIEF.md
# Raster Timing Generator with Interlace Support

This block produces the timing of a display raster from values written into a small register set. Each line and each frame are cut into four phases, taken in the order sync, back porch, active, front porch. The horizontal lengths are counted in pixel clocks, and the vertical lengths are counted in whole lines. From these counters the block drives active-high horizontal and vertical sync, a data-enable, a field indicator, and a pixel-request strobe for the upstream pixel source. It also drives a one-cycle frame-start marker. The pixel source uses this marker to wait before it begins to deliver pixels.

Two vertical parameter sets are kept, one for the odd field and one for the even field. In progressive operation only the odd set is used. In interlaced operation the two sets alternate, one per frame. Software normally programs the even-field back porch one line shorter than the odd-field back porch, and programs half the frame height as the active line count of each field. An interrupt status flag sets when the vertical front porch begins. Writing 1 to it clears it, and it reaches the interrupt line only when its enable is set. Clearing the run bit never cuts a frame short: the current frame finishes, then the counters return to their start point and the `video_on` status drops. Software can poll `video_on` to learn when shutdown is complete.

Registers are written through a plain write port. All timing fields are TW bits wide (default 12) and must be programmed nonzero.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every output is low, and no timing is produced until bit 0 of the control word (address 6) is written as 1.
- R2: Each line runs sync, back porch, active, front porch. The lengths come from address 0 (sync in bits [TW-1:0], back porch in bits [2TW-1:TW]) and address 1 (active in the low field, front porch in the high field). A line lasts the sum of the four lengths.
- R3: Each frame runs the same four phases counted in lines. The lengths come from the vertical pair of the current field: odd at addresses 2 and 3, even at addresses 4 and 5, with the same field layout as R2. `vsync` covers whole lines, and a frame lasts line length times the vertical sum.
- R4: `de` is high only when both the horizontal and the vertical phase are active. `px_req` is never high outside `de`.
- R5: Setting the run bit while idle starts output on the next cycle. That first cycle has `frame_start`, `hsync` and `vsync` all high.
- R6: With control bit 2 set (interlaced), the first frame is the odd field (`field` = 0) and uses the odd set. `field` toggles at each frame end, and frames with `field` = 1 use the even set.
- R7: With control bit 2 clear (progressive), `field` stays 0 and the even set has no effect on timing.
- R8: The interrupt status sets in the first cycle of the vertical front porch. `irq` equals that status ANDed with bit 0 of address 8.
- R9: Writing 1 to bit 0 of address 9 clears the interrupt status. Writing 0 there leaves it unchanged.
- R10: Clearing the run bit mid-frame lets that frame complete. `video_on` then falls in the cycle after the frame's last cycle, and no timing output rises afterwards.
- R11: With control bit 1 (continuous) clear, exactly one frame is produced. The block then clears the run bit itself, so output does not restart.
- R12: A request limit at address 7 that is nonzero and smaller than the active width restricts `px_req` to the first limit pixels of each active line. A limit of 0, or one not smaller than the active width, gives a request on every active pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable, high in the active area |
| field | output | 1 | Field indicator, 0 odd, 1 even |
| px_req | output | 1 | Pixel request to the upstream source |
| frame_start | output | 1 | One-cycle marker on the first cycle of each frame |
| irq | output | 1 | Vertical front porch interrupt |
| video_on | output | 1 | High while the generator is running |

## Verification
The hardest state to reach is a shutdown request that arrives in the middle of an interlaced sequence. A wrong implementation could stop at the wrong frame, or stop early, while still looking correct at each individual output. The stimulus runs each table mode for a full odd and even field pair. It then clears the run bit in the second cycle of the next frame and counts the cycles until `video_on` falls, expecting the length of an odd frame. The one-shot mode is run with the interrupt masked. This leaves a pending status that is then revealed by setting the mask and removed by the write-1 clear.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } phase_e;

   // register word addresses
   localparam int unsigned ADR_H_LO   = 0;
   localparam int unsigned ADR_H_HI   = 1;
   localparam int unsigned ADR_VO_LO  = 2;
   localparam int unsigned ADR_VO_HI  = 3;
   localparam int unsigned ADR_VE_LO  = 4;
   localparam int unsigned ADR_VE_HI  = 5;
   localparam int unsigned ADR_CTRL   = 6;
   localparam int unsigned ADR_LIMIT  = 7;
   localparam int unsigned ADR_IRQ_EN = 8;
   localparam int unsigned ADR_IRQ_ST = 9;
   localparam int unsigned NUM_ADR    = 10;

   localparam int unsigned TIM_WORDS  = 6;
   localparam int unsigned NUM_SETS   = 3;

   // control bit positions
   localparam int unsigned CB_RUN     = 0;
   localparam int unsigned CB_CONT    = 1;
   localparam int unsigned CB_ILACE   = 2;

   function automatic phase_e phase_after(input phase_e p);
      case (p)
         PH_SYNC:  return PH_BACK;
         PH_BACK:  return PH_ACT;
         PH_ACT:   return PH_FRONT;
         default:  return PH_SYNC;
      endcase
   endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
   import rtg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned TW     = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   st_set,
   input  logic                   run_drop,
   output logic [3:0][TW-1:0]     h_len,
   output logic [3:0][TW-1:0]     vo_len,
   output logic [3:0][TW-1:0]     ve_len,
   output logic [TW-1:0]          req_lim,
   output logic                   cfg_run,
   output logic                   cfg_cont,
   output logic                   cfg_ilace,
   output logic                   irq_en,
   output logic                   irq_st
);

   localparam int unsigned PAIR_W = 2 * TW;

   logic [TIM_WORDS-1:0][PAIR_W-1:0] tim_q;
   logic [NUM_SETS-1:0][3:0][TW-1:0] set_len;
   logic                             unused_wdata;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned n);
      return a == ADDR_W'(n);
   endfunction

   // timing words, two fields each
   for (genvar w = 0; w < TIM_WORDS; w++) begin : g_tim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tim_q[w] <= '0;
         else if (wr_en && hit(wr_addr, w))
            tim_q[w] <= wr_data[PAIR_W-1:0];
      end
   end

   // unpack: set s, phase k -> word 2s + k/2, half k%2
   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      for (genvar k = 0; k < 4; k++) begin : g_ph
         assign set_len[s][k] = tim_q[2*s + k/2][(k%2)*TW +: TW];
      end
   end

   assign h_len  = set_len[0];
   assign vo_len = set_len[1];
   assign ve_len = set_len[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_run   <= 1'b0;
         cfg_cont  <= 1'b0;
         cfg_ilace <= 1'b0;
      end else if (wr_en && hit(wr_addr, ADR_CTRL)) begin
         cfg_run   <= wr_data[CB_RUN];
         cfg_cont  <= wr_data[CB_CONT];
         cfg_ilace <= wr_data[CB_ILACE];
      end else if (run_drop) begin
         cfg_run   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req_lim <= '0;
      else if (wr_en && hit(wr_addr, ADR_LIMIT))
         req_lim <= wr_data[TW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_en <= 1'b0;
      else if (wr_en && hit(wr_addr, ADR_IRQ_EN))
         irq_en <= wr_data[0];
   end

   // a new event wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_st <= 1'b0;
      else if (st_set)
         irq_st <= 1'b1;
      else if (wr_en && hit(wr_addr, ADR_IRQ_ST) && wr_data[0])
         irq_st <= 1'b0;
   end

   assign unused_wdata = ^wr_data;

endmodule

// File: rtl/rtg_span_ctr.sv
module rtg_span_ctr
   import rtg_pkg::*;
#(
   parameter int unsigned TW = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic               adv,
   input  logic [3:0][TW-1:0] len,
   output phase_e             phase,
   output logic [TW-1:0]      cnt,
   output logic               wrap,
   output logic               enter_front
);

   logic [TW-1:0] cur_len;
   logic [TW-1:0] cur_last;
   logic          at_end;

   always_comb begin
      cur_len  = len[phase];
      cur_last = (cur_len == '0) ? '0 : cur_len - TW'(1);
   end

   assign at_end      = (cnt == cur_last);
   assign wrap        = at_end && (phase == PH_FRONT);
   assign enter_front = adv && at_end && (phase == PH_ACT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (hold) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (adv) begin
         if (at_end) begin
            cnt   <= '0;
            phase <= phase_after(phase);
         end else begin
            cnt   <= cnt + TW'(1);
         end
      end
   end

endmodule

// File: rtl/rtg_req_gate.sv
module rtg_req_gate #(
   parameter int unsigned TW       = 12,
   parameter bit          LIMIT_EN = 1'b1
) (
   input  logic          de,
   input  logic [TW-1:0] h_cnt,
   input  logic [TW-1:0] h_act,
   input  logic [TW-1:0] lim,
   output logic          px_req
);

   if (LIMIT_EN) begin : g_limited
      logic lim_off;
      assign lim_off = (lim == '0) || (lim >= h_act);
      assign px_req  = de && (lim_off || (h_cnt < lim));
   end else begin : g_plain
      logic unused_gate;
      assign unused_gate = ^{h_cnt, h_act, lim};
      assign px_req      = de;
   end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned TW       = 12,
   parameter bit          LIMIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic              field,
   output logic              px_req,
   output logic              frame_start,
   output logic              irq,
   output logic              video_on
);

   localparam int unsigned ADR_SPACE = 1 << ADDR_W;

   if (2 * TW > DATA_W) begin : g_bad_width
      $error("two timing fields must fit one data word");
   end
   if (ADR_SPACE < NUM_ADR) begin : g_bad_addr
      $error("address width too small for the register set");
   end
   if (TW < 2) begin : g_bad_tw
      $error("timing field width too small");
   end

   logic [3:0][TW-1:0] h_len, vo_len, ve_len, v_len;
   logic [TW-1:0]      req_lim;
   logic               cfg_run, cfg_cont, cfg_ilace, irq_en, irq_st;
   logic               running_q, field_q;
   phase_e             h_ph, v_ph;
   logic [TW-1:0]      h_cnt, v_cnt;
   logic               h_wrap, v_wrap, v_front, unused_h_front;
   logic               frame_end, halt, run_drop;

   rtg_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .TW     (TW)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .st_set    (v_front),
      .run_drop  (run_drop),
      .h_len     (h_len),
      .vo_len    (vo_len),
      .ve_len    (ve_len),
      .req_lim   (req_lim),
      .cfg_run   (cfg_run),
      .cfg_cont  (cfg_cont),
      .cfg_ilace (cfg_ilace),
      .irq_en    (irq_en),
      .irq_st    (irq_st)
   );

   assign v_len = (cfg_ilace && field_q) ? ve_len : vo_len;

   rtg_span_ctr #(.TW(TW)) i_hctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold        (!running_q),
      .adv         (running_q),
      .len         (h_len),
      .phase       (h_ph),
      .cnt         (h_cnt),
      .wrap        (h_wrap),
      .enter_front (unused_h_front)
   );

   rtg_span_ctr #(.TW(TW)) i_vctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold        (!running_q),
      .adv         (running_q && h_wrap),
      .len         (v_len),
      .phase       (v_ph),
      .cnt         (v_cnt),
      .wrap        (v_wrap),
      .enter_front (v_front)
   );

   assign frame_end = running_q && h_wrap && v_wrap;
   assign halt      = frame_end && (!cfg_run || !cfg_cont);
   assign run_drop  = frame_end && !cfg_cont;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         running_q <= 1'b0;
      else if (!running_q)
         running_q <= cfg_run;
      else if (halt)
         running_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         field_q <= 1'b0;
      else if (!running_q)
         field_q <= 1'b0;
      else if (frame_end && cfg_ilace)
         field_q <= !field_q;
   end

   assign hsync       = running_q && (h_ph == PH_SYNC);
   assign vsync       = running_q && (v_ph == PH_SYNC);
   assign de          = running_q && (h_ph == PH_ACT) && (v_ph == PH_ACT);
   assign frame_start = running_q && (h_ph == PH_SYNC) && (v_ph == PH_SYNC)
                        && (h_cnt == '0) && (v_cnt == '0);
   assign field       = field_q;
   assign irq         = irq_st && irq_en;
   assign video_on    = running_q;

   rtg_req_gate #(
      .TW       (TW),
      .LIMIT_EN (LIMIT_EN)
   ) i_gate (
      .de     (de),
      .h_cnt  (h_cnt),
      .h_act  (h_len[PH_ACT]),
      .lim    (req_lim),
      .px_req (px_req)
   );

endmodule

// File: rtl/rtg_chk.sv
module rtg_chk (
   input logic clk,
   input logic rst_n,
   input logic hsync,
   input logic vsync,
   input logic de,
   input logic field,
   input logic px_req,
   input logic frame_start,
   input logic video_on
);

   // R4
   px_within_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
      px_req |-> de);

   // R4
   de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (!hsync && !vsync));

   // R5
   start_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (hsync && vsync));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !video_on |-> (!hsync && !vsync && !de && !px_req && !frame_start));

   // R10
   stop_after_porch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(video_on) |-> (!$past(vsync) && !$past(de)));

   // R6
   field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (video_on && !frame_start) |-> $stable(field));

endmodule

bind raster_timing_gen rtg_chk i_rtg_chk (.*);

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;

   typedef struct packed {
      logic [7:0] hs, hb, ha, hf;
      logic [7:0] vs, vb, va, vf;
      logic [7:0] vbe, lim;
      logic       il;
   } mode_t;

   localparam int NMODES = 5;
   localparam mode_t MODES [NMODES] = '{
      '{8'd2, 8'd3, 8'd8,  8'd2, 8'd1, 8'd2, 8'd4, 8'd2, 8'd7, 8'd0,  1'b0},
      '{8'd1, 8'd1, 8'd6,  8'd1, 8'd2, 8'd1, 8'd3, 8'd1, 8'd4, 8'd4,  1'b0},
      '{8'd3, 8'd2, 8'd10, 8'd4, 8'd1, 8'd3, 8'd5, 8'd2, 8'd2, 8'd12, 1'b1},
      '{8'd1, 8'd2, 8'd5,  8'd3, 8'd2, 8'd2, 8'd2, 8'd1, 8'd1, 8'd5,  1'b1},
      '{8'd4, 8'd1, 8'd7,  8'd2, 8'd1, 8'd1, 8'd2, 8'd3, 8'd3, 8'd1,  1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [3:0]  wr_addr;
   logic [31:0] wr_data;
   logic        hsync, vsync, de, field, px_req, frame_start, irq, video_on;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   raster_timing_gen i_raster_timing_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .hsync       (hsync),
      .vsync       (vsync),
      .de          (de),
      .field       (field),
      .px_req      (px_req),
      .frame_start (frame_start),
      .irq         (irq),
      .video_on    (video_on)
   );

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      wr_en   = 1'b1;
      wr_addr = a[3:0];
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_start();
      int g = 0;
      while (!frame_start && g < 5000) begin
         @(negedge clk);
         g++;
      end
   endtask

   task automatic wait_idle();
      int g = 0;
      while (video_on && g < 5000) begin
         @(negedge clk);
         g++;
      end
   endtask

   task automatic program_mode(input mode_t m);
      wr(0, {8'd0, 4'd0, m.hb, 4'd0, m.hs});
      wr(1, {8'd0, 4'd0, m.hf, 4'd0, m.ha});
      wr(2, {8'd0, 4'd0, m.vb, 4'd0, m.vs});
      wr(3, {8'd0, 4'd0, m.vf, 4'd0, m.va});
      wr(4, {8'd0, 4'd0, m.vbe, 4'd0, m.vs});
      wr(5, {8'd0, 4'd0, m.vf, 4'd0, m.va});
      wr(7, {24'd0, m.lim});
   endtask

   // called at the negedge where frame_start is high
   task automatic measure(output int len, output int de_n, output int hs_n,
                          output int vs_n, output int px_n, output int irq_off,
                          output int de_off, output int fld, output int fld_bad);
      len = 0; de_n = 0; hs_n = 0; vs_n = 0; px_n = 0;
      irq_off = -1; de_off = -1; fld = int'(field); fld_bad = 0;
      wr_en = 1'b1; wr_addr = 4'd9; wr_data = 32'd1;
      while (1) begin
         if (de) begin
            de_n++;
            if (de_off < 0) de_off = len;
         end
         if (hsync)  hs_n++;
         if (vsync)  vs_n++;
         if (px_req) px_n++;
         if (irq && len >= 1 && irq_off < 0) irq_off = len;
         if (int'(field) != fld) fld_bad++;
         @(negedge clk);
         len++;
         if (len == 1) wr_en = 1'b0;
         if (frame_start || len >= 5000) break;
      end
   endtask

   task automatic run_mode(input int idx, input mode_t m);
      int ht, vto, vte, eff;
      int len, de_n, hs_n, vs_n, px_n, irq_off, de_off, fld, fld_bad;
      int cnt, starts;
      ht  = m.hs + m.hb + m.ha + m.hf;
      vto = m.vs + m.vb + m.va + m.vf;
      vte = m.vs + m.vbe + m.va + m.vf;
      eff = (m.lim == 0 || m.lim >= m.ha) ? int'(m.ha) : int'(m.lim);

      wr(6, 32'd0);
      wait_idle();
      program_mode(m);
      wr(8, 32'd1);
      wr(6, {29'd0, m.il, 1'b1, 1'b1});
      wait_start();
      chk($sformatf("R5 mode%0d hsync at frame start", idx), int'(hsync), 1);
      chk($sformatf("R5 mode%0d vsync at frame start", idx), int'(vsync), 1);

      measure(len, de_n, hs_n, vs_n, px_n, irq_off, de_off, fld, fld_bad);
      chk($sformatf("R3 mode%0d odd frame length", idx), len, ht * vto);
      chk($sformatf("R2 mode%0d first active offset", idx), de_off,
          ht * (m.vs + m.vb) + m.hs + m.hb);
      chk($sformatf("R2 mode%0d hsync cycles", idx), hs_n, m.hs * vto);
      chk($sformatf("R3 mode%0d vsync cycles", idx), vs_n, m.vs * ht);
      chk($sformatf("R4 mode%0d de cycles", idx), de_n, m.ha * m.va);
      chk($sformatf("R12 mode%0d request cycles", idx), px_n, eff * m.va);
      chk($sformatf("R8 mode%0d irq offset", idx), irq_off, ht * (m.vs + m.vb + m.va));
      chk($sformatf("R6 R7 mode%0d first field", idx), fld, 0);
      chk($sformatf("R6 R7 mode%0d field steady", idx), fld_bad, 0);

      if (m.il) begin
         measure(len, de_n, hs_n, vs_n, px_n, irq_off, de_off, fld, fld_bad);
         chk($sformatf("R6 mode%0d even frame length", idx), len, ht * vte);
         chk($sformatf("R6 mode%0d even first active offset", idx), de_off,
             ht * (m.vs + m.vbe) + m.hs + m.hb);
         chk($sformatf("R6 mode%0d even field value", idx), fld, 1);
      end else begin
         measure(len, de_n, hs_n, vs_n, px_n, irq_off, de_off, fld, fld_bad);
         chk($sformatf("R7 mode%0d second frame length", idx), len, ht * vto);
         chk($sformatf("R7 mode%0d second field value", idx), fld, 0);
      end

      // R10: clear the run bit in the second cycle of this frame
      cnt = 0; starts = 0;
      while (video_on && cnt < 5000) begin
         if (cnt == 1) begin
            wr_en = 1'b1; wr_addr = 4'd6; wr_data = {29'd0, m.il, 1'b1, 1'b0};
         end
         if (cnt == 2) wr_en = 1'b0;
         if (frame_start && cnt > 0) starts++;
         @(negedge clk);
         cnt++;
      end
      wr_en = 1'b0;
      chk($sformatf("R10 mode%0d cycles until stop", idx), cnt, ht * vto);
      chk($sformatf("R10 mode%0d no restart inside frame", idx), starts, 0);
      starts = 0;
      for (int c = 0; c < ht * vto; c++) begin
         if (frame_start || hsync || vsync || de) starts++;
         @(negedge clk);
      end
      chk($sformatf("R10 mode%0d quiet after stop", idx), starts, 0);
   endtask

   initial begin
      int starts, irq_hi, flen;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 hsync after reset", int'(hsync), 0);
      chk("R1 vsync after reset", int'(vsync), 0);
      chk("R1 de after reset", int'(de), 0);
      chk("R1 irq after reset", int'(irq), 0);
      chk("R1 video_on after reset", int'(video_on), 0);
      repeat (20) @(negedge clk);
      chk("R1 no start without run bit", int'(video_on || frame_start), 0);

      for (int i = 0; i < NMODES; i++) run_mode(i, MODES[i]);

      // R11 single frame with interrupt masked
      program_mode(MODES[0]);
      wr(8, 32'd0);
      wr(9, 32'd1);
      flen = 15 * 9;
      wr(6, 32'd1);
      starts = 0; irq_hi = 0;
      for (int c = 0; c < 3 * flen; c++) begin
         if (frame_start) starts++;
         if (irq) irq_hi++;
         @(negedge clk);
      end
      chk("R11 single frame count", starts, 1);
      chk("R11 stopped after single frame", int'(video_on), 0);
      chk("R8 masked irq stays low", irq_hi, 0);
      wr(8, 32'd1);
      chk("R8 pending status reaches irq once enabled", int'(irq), 1);
      wr(9, 32'd0);
      chk("R9 writing zero keeps status", int'(irq), 1);
      wr(9, 32'd1);
      chk("R9 writing one clears status", int'(irq), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #500000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule